// File: doc/BRIEF.md
# Acquisition Trigger and Gate Controller

This block decides when a converter acquisition runs. An asynchronous external trigger/gate pin is synchronised and then read either as an edge (rising or falling) or as a level (active high or active low). A software trigger strobe and a software stop strobe are combined with that input to form a registered run enable for the converter.

Each accepted trigger, meaning one that starts a run, emits a registered pulse lasting one microsecond. The length of this pulse in clock cycles is a parameter equal to the clock frequency in MHz. Several converters can be started together by sharing this pulse. The pulse leaves the chip on a pin that it shares with a timer clock output. A registered mux selects which of the two drives the pin. While the trigger output owns the pin, a registered enable holds the timer off.

Top module: `acq_trig_ctrl`

## Requirements
- R1: A change on `ext_trig` takes effect on `acq_run` and `conv_trig` at the third rising clock edge after it, because two synchroniser flops and one output register sit on the path.
- R2: With `cfg_level`=0 (edge mode), `cfg_pol`=0 accepts rising edges of the synchronised input and `cfg_pol`=1 accepts falling edges. An accepted edge while idle sets `acq_run`.
- R3: In edge mode, while `acq_run`=1, a further event clears `acq_run` when `cfg_edge_stop`=1. When `cfg_edge_stop`=0 the event has no effect. Neither case produces a pulse.
- R4: In edge mode, `sw_stop` sampled high clears `acq_run` at that edge and wins over an event in the same cycle.
- R5: With `cfg_level`=1, `acq_run` is high exactly while the synchronised input sits at its active level (high when `cfg_pol`=0, low when `cfg_pol`=1) and `ext_en`=1, with the same latency as R1. `sw_trig` and `sw_stop` have no effect in this mode.
- R6: An accepted trigger drives `conv_trig` high for exactly CLK_MHZ cycles. In level mode the accepted trigger is the move of the synchronised input to its active level. A new accepted trigger during a pulse restarts the full count.
- R7: In edge mode, `sw_trig` sampled high counts as an event exactly like an external edge, including the pulse. `acq_run` and `conv_trig` respond at that same edge.
- R8: With `ext_en`=0, the external input neither starts, stops nor gates acquisition.
- R9: `shared_pin` equals the previous cycle's `conv_trig` when the previous cycle's `trigout_en`=1. Otherwise it equals the previous cycle's `timer_clk`.
- R10: `timer_allow` equals the inverse of the previous cycle's `trigout_en`.
- R11: While `rst` is high, `acq_run`, `conv_trig`, `shared_pin` and `timer_allow` are all 0 from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_MHZ MHz |
| rst | input | 1 | Synchronous active-high reset |
| ext_trig | input | 1 | Asynchronous external trigger/gate pin |
| ext_en | input | 1 | Enables the external source |
| cfg_level | input | 1 | 0 = edge mode, 1 = level mode |
| cfg_pol | input | 1 | Edge: 0 rising, 1 falling; level: 0 active high, 1 active low |
| cfg_edge_stop | input | 1 | Edge mode: 1 = next event stops the run |
| sw_trig | input | 1 | Software trigger strobe |
| sw_stop | input | 1 | Software stop strobe (edge mode) |
| trigout_en | input | 1 | 1 = trigger pulse owns the shared pin |
| timer_clk | input | 1 | Clock output of the timer sharing the pin |
| acq_run | output | 1 | Registered acquisition run enable |
| conv_trig | output | 1 | Registered one-microsecond trigger pulse |
| shared_pin | output | 1 | Registered shared pin drive |
| timer_allow | output | 1 | Registered timer enable, low while the pin is taken |

## Verification
The input is driven in separate phases:
- rising-edge mode with stop-on-edge, which tells apart start events from stop events;
- falling-edge mode with run-until-stop plus software stops, which shows the priority of a stop over an event;
- active-high and active-low level mode with fast toggling, which shows gating and pulse restarts;
- software triggers with the external source disabled, which shows that the sources are independent;
- frequent pin-owner changes, which exercise the mux.

Directed cases measure the three-edge latency and the exact pulse length.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;
  typedef enum logic {
    GATE_EDGE  = 1'b0,
    GATE_LEVEL = 1'b1
  } gate_mode_e;
endpackage

// File: rtl/atc_sync.sv
module atc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/atc_gate_fsm.sv
module atc_gate_fsm
  import acq_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_sync,
  input  logic       ext_en,
  input  gate_mode_e mode,
  input  logic       pol,
  input  logic       edge_stop,
  input  logic       sw_trig,
  input  logic       sw_stop,
  output logic       run,
  output logic       accept
);
  logic prev_q, run_q, run_d;
  logic rise, fall, ext_evt, gate_on, evt;

  assign rise    = in_sync & ~prev_q;
  assign fall    = ~in_sync & prev_q;
  assign ext_evt = ext_en & (pol ? fall : rise);
  assign gate_on = ext_en & (in_sync ^ pol);
  assign evt     = ext_evt | sw_trig;

  always_comb begin
    run_d  = run_q;
    accept = 1'b0;
    if (mode == GATE_LEVEL) begin
      run_d  = gate_on;
      accept = ext_evt;
    end else if (sw_stop) begin
      run_d = 1'b0;
    end else if (evt) begin
      if (!run_q) begin
        run_d  = 1'b1;
        accept = 1'b1;
      end else if (edge_stop) begin
        run_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      prev_q <= in_sync;
      run_q  <= run_d;
    end
  end

  assign run = run_q;
endmodule

// File: rtl/atc_pulse_gen.sv
module atc_pulse_gen #(
  parameter int PULSE_CYC = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic pulse
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  logic [CW-1:0] left_q;
  logic          pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      pulse_q <= 1'b0;
    end else if (load) begin
      left_q  <= CW'(PULSE_CYC - 1);
      pulse_q <= 1'b1;
    end else if (left_q != '0) begin
      left_q  <= left_q - CW'(1);
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/atc_pin_mux.sv
module atc_pin_mux (
  input  logic clk,
  input  logic rst,
  input  logic own_trig,
  input  logic trig_src,
  input  logic timer_src,
  output logic pin,
  output logic timer_ok
);
  logic pin_q, ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      ok_q  <= 1'b0;
    end else begin
      pin_q <= own_trig ? trig_src : timer_src;
      ok_q  <= ~own_trig;
    end
  end

  assign pin      = pin_q;
  assign timer_ok = ok_q;
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
  import acq_trig_pkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_trig,
  input  logic ext_en,
  input  logic cfg_level,
  input  logic cfg_pol,
  input  logic cfg_edge_stop,
  input  logic sw_trig,
  input  logic sw_stop,
  input  logic trigout_en,
  input  logic timer_clk,
  output logic acq_run,
  output logic conv_trig,
  output logic shared_pin,
  output logic timer_allow
);
  logic       trig_s;
  logic       accept;
  gate_mode_e mode;

  assign mode = gate_mode_e'(cfg_level);

  atc_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(ext_trig), .q(trig_s)
  );

  atc_gate_fsm gate_i (
    .clk(clk), .rst(rst), .in_sync(trig_s), .ext_en(ext_en), .mode(mode),
    .pol(cfg_pol), .edge_stop(cfg_edge_stop), .sw_trig(sw_trig),
    .sw_stop(sw_stop), .run(acq_run), .accept(accept)
  );

  atc_pulse_gen #(.PULSE_CYC(CLK_MHZ)) pulse_i (
    .clk(clk), .rst(rst), .load(accept), .pulse(conv_trig)
  );

  atc_pin_mux mux_i (
    .clk(clk), .rst(rst), .own_trig(trigout_en), .trig_src(conv_trig),
    .timer_src(timer_clk), .pin(shared_pin), .timer_ok(timer_allow)
  );
endmodule

// File: rtl/acq_trig_ctrl_chk.sv
module acq_trig_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic ext_trig,
  input logic ext_en,
  input logic cfg_level,
  input logic cfg_pol,
  input logic cfg_edge_stop,
  input logic sw_trig,
  input logic sw_stop,
  input logic trigout_en,
  input logic timer_clk,
  input logic acq_run,
  input logic conv_trig,
  input logic shared_pin,
  input logic timer_allow
);
  AST_PULSE_WITH_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_trig) |-> acq_run); // R6

  AST_SW_STOP_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(sw_stop && !cfg_level) |-> !acq_run); // R4

  AST_TIMER_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(trigout_en) |-> !timer_allow); // R10

  AST_PIN_FROM_TRIG: assert property (@(posedge clk) disable iff (rst)
    ($past(trigout_en) && !$past(rst)) |-> (shared_pin == $past(conv_trig))); // R9

  AST_PIN_FROM_TIMER: assert property (@(posedge clk) disable iff (rst)
    (!$past(trigout_en) && !$past(rst)) |-> (shared_pin == $past(timer_clk))); // R9

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!acq_run && !conv_trig && !timer_allow)); // R11
endmodule

bind acq_trig_ctrl acq_trig_ctrl_chk chk_i (.*);

// File: tb/acq_trig_ctrl_tb_top.sv
module acq_trig_ctrl_tb_top;
  localparam int N = 125;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_trig = 0, ext_en = 0, cfg_level = 0, cfg_pol = 0, cfg_edge_stop = 0;
  logic sw_trig = 0, sw_stop = 0, trigout_en = 0, timer_clk = 0;
  logic acq_run, conv_trig, shared_pin, timer_allow;

  int    checks = 0, fails = 0;
  bit    done = 0;
  string cur_req = "R11";

  always #4 clk = ~clk;

  acq_trig_ctrl #(.CLK_MHZ(N)) dut_i (
    .clk(clk), .rst(rst), .ext_trig(ext_trig), .ext_en(ext_en),
    .cfg_level(cfg_level), .cfg_pol(cfg_pol), .cfg_edge_stop(cfg_edge_stop),
    .sw_trig(sw_trig), .sw_stop(sw_stop), .trigout_en(trigout_en),
    .timer_clk(timer_clk), .acq_run(acq_run), .conv_trig(conv_trig),
    .shared_pin(shared_pin), .timer_allow(timer_allow)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  logic m_s1, m_s2, m_p, m_run, m_pin, m_tallow;
  int   m_left;

  function automatic bit accepted_edge(bit s2, bit p, bit en, bit pol);
    return en && (pol ? (!s2 && p) : (s2 && !p));
  endfunction

  always @(posedge clk) begin
    bit ext, gate, acc, nrun, oldp;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_p = 0; m_run = 0; m_pin = 0; m_tallow = 0; m_left = 0;
    end else begin
      ext  = accepted_edge(m_s2, m_p, ext_en, cfg_pol);
      gate = ext_en && (m_s2 != cfg_pol);
      acc  = 0;
      nrun = m_run;
      if (cfg_level) begin
        nrun = gate; acc = ext;
      end else if (sw_stop) begin
        nrun = 0;
      end else if (ext || sw_trig) begin
        if (!m_run) begin nrun = 1; acc = 1; end
        else if (cfg_edge_stop) nrun = 0;
      end
      oldp     = (m_left > 0);
      m_pin    = trigout_en ? oldp : timer_clk;
      m_tallow = !trigout_en;
      if (acc) m_left = N;
      else if (m_left > 0) m_left--;
      m_run = nrun; m_p = m_s2; m_s2 = m_s1; m_s1 = ext_trig;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "acq_run", acq_run, m_run);
      chk(cur_req, "conv_trig", conv_trig, m_left > 0);
      chk("R9", "shared_pin", shared_pin, m_pin);
      chk("R10", "timer_allow", timer_allow, m_tallow);
    end
  end

  task automatic random_phase(string req, bit lvl, bit pol, bit stp, bit en,
                              int trig_rate, int sw_rate, int own_rate);
    cur_req = req;
    @(negedge clk);
    cfg_level = lvl; cfg_pol = pol; cfg_edge_stop = stp; ext_en = en;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(trig_rate - 1) == 0) ext_trig = ~ext_trig;
      sw_trig   = ($urandom_range(sw_rate - 1) == 0);
      sw_stop   = ($urandom_range(59) == 0);
      timer_clk = $urandom_range(1);
      if ($urandom_range(own_rate - 1) == 0) trigout_en = ~trigout_en;
    end
    @(negedge clk);
    sw_trig = 0; sw_stop = 0;
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "acq_run in reset", acq_run, 1'b0);
    chk("R11", "conv_trig in reset", conv_trig, 1'b0);
    chk("R11", "timer_allow in reset", timer_allow, 1'b0);
    chk("R11", "shared_pin in reset", shared_pin, 1'b0);
    rst = 0;

    random_phase("R2 R3", 0, 0, 1, 1, 8, 400, 500);
    random_phase("R3 R4", 0, 1, 0, 1, 8, 300, 500);
    random_phase("R5 R6", 1, 0, 0, 1, 20, 30, 500);
    random_phase("R5 R6", 1, 1, 1, 1, 20, 30, 500);
    random_phase("R7 R8", 0, 0, 1, 0, 4, 40, 500);
    random_phase("R9 R10", 0, 0, 0, 1, 10, 50, 6);

    // R1 and R6 directed: idle, rising-edge mode, pulse owns pin
    cur_req = "R1";
    @(negedge clk);
    cfg_level = 0; cfg_pol = 0; cfg_edge_stop = 1; ext_en = 1;
    trigout_en = 1; ext_trig = 0; sw_stop = 1;
    @(negedge clk);
    sw_stop = 0;
    repeat (N + 5) @(negedge clk);
    ext_trig = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R1", "acq_run after two edges", acq_run, 1'b0);
    @(negedge clk);
    chk("R1", "acq_run after three edges", acq_run, 1'b1);
    chk("R1", "conv_trig after three edges", conv_trig, 1'b1);
    begin
      int n = 0;
      while (conv_trig === 1'b1 && n < 4 * N) begin
        n++;
        @(negedge clk);
      end
      checks++;
      if (n != N) begin
        fails++;
        $display("FAIL R6 pulse length actual=%0d expected=%0d", n, N);
      end
    end
    // R7 directed: sw_trig stops the run (edge_stop=1), no new pulse
    sw_trig = 1;
    @(negedge clk);
    sw_trig = 0;
    chk("R7", "sw_trig as stop event", acq_run, 1'b0);
    chk("R7", "no pulse on stop event", conv_trig, 1'b0);
    repeat (3) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule